// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a 16-bit SDRAM with four banks, 12 row bits and 8 column bits. After reset it brings the device up with a fixed sequence. It first enables the memory clock, then waits out a power-up delay. It then precharges every bank, issues five auto-refresh commands and writes the mode register. All spacing is counted in controller clock cycles. NOP is driven in every cycle that carries no command.

Once the device is configured, the block raises a ready flag and hands the command bus to a user port. It takes the bus back only to issue a periodic auto-refresh. The refresh interval (1292 cycles by default) covers 4096 rows in 64 ms at an 84 MHz clock, less a margin of 20 cycles. When the interval expires, a refresh becomes pending. The refresh goes out as soon as the user port stops holding the bus, and the bus stays closed for one row-cycle time after it.

Top module: `sdram_pwrup_refresh`

## Requirements
- R1: While reset is asserted, the outputs are as follows. CKE is low. The command {CS#,RAS#,CAS#,WE#} is NOP (0111). Ready and grant are low.
- R2: CKE goes high in the first cycle after reset is released and stays high until the next reset.
- R3: The first non-NOP command is Precharge All (0010, with A10 high). It appears exactly PWRUP_CLKS cycles after CKE rises.
- R4: Exactly five Auto Refresh commands (0001) follow the precharge. The first comes TRP (2) cycles after the precharge. Each later one comes TRC (6) cycles after the previous one.
- R5: Load Mode (0000) is issued TRC cycles after the last initial refresh, with BA = 00 and A[11:0] = 0x221. The address bits encode the mode word: A[2:0] = 001 (burst length 2), A3 = 0 (sequential), A[6:4] = 010 (CAS latency 2), A[8:7] = 00 (normal operation), A9 = 1 (single-location write).
- R6: Ready rises exactly TMRD (2) cycles after Load Mode and stays high until reset.
- R7: While the user port does not hold the bus, the first periodic refresh appears REF_INTERVAL+1 cycles after ready rises. Later periodic refreshes are exactly REF_INTERVAL cycles apart.
- R8: Grant drops in the cycle of a periodic refresh. It comes back exactly TRC cycles later.
- R9: While grant is high and user_hold is high, the command pins, BA and A follow the user inputs. While grant is high and user_hold is low, the pins show NOP and the user inputs are ignored.
- R10: While user_hold is high, no refresh is issued, even after the interval expires. The pending refresh appears in the cycle after user_hold is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| user_hold | input | 1 | User port claims the command bus |
| user_cs_n | input | 1 | User chip select, active low |
| user_ras_n | input | 1 | User row strobe, active low |
| user_cas_n | input | 1 | User column strobe, active low |
| user_we_n | input | 1 | User write enable, active low |
| user_ba | input | 2 | User bank address |
| user_addr | input | 12 | User address |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 12 | SDRAM address |
| sd_ready | output | 1 | Initialization complete |
| sd_grant | output | 1 | User port may drive the command bus |

## Verification
The hardest case to reach is a refresh interval that expires while the user port is holding the bus. The pending request has to survive the wait and then be issued one cycle after the release. To reach it, the stimulus waits for a refresh and its recovery window to finish. It then asserts user_hold with an Activate pattern and keeps it high for more than one full interval. During the hold it checks every cycle that the user command reaches the pins and no refresh does. It then drops the hold and measures the cycle in which the deferred refresh appears.

// File: rtl/sdr_seq_pkg.sv
// Shared definitions for the SDRAM sequencer: command codes on
// {CS#,RAS#,CAS#,WE#}, sequencer states and the mode word builder.
package sdr_seq_pkg;

    typedef logic [3:0] sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = 4'b0111;
    localparam sdr_cmd_t CMD_PRE = 4'b0010;
    localparam sdr_cmd_t CMD_REF = 4'b0001;
    localparam sdr_cmd_t CMD_LMR = 4'b0000;

    // Mode field codes
    localparam logic [2:0] MW_BURST_2   = 3'b001;
    localparam logic       MW_SEQ       = 1'b0;
    localparam logic [2:0] MW_CAS_2     = 3'b010;
    localparam logic [1:0] MW_OP_NORMAL = 2'b00;
    localparam logic       MW_WR_SINGLE = 1'b1;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_PWRUP,
        ST_PRE_WAIT,
        ST_AR_WAIT,
        ST_LMR_WAIT,
        ST_USER,
        ST_REF_WAIT
    } sdr_state_t;

    // Assemble the 12-bit mode word from its fields
    function automatic logic [11:0] build_mode(input logic [2:0] burst,
                                               input logic       btype,
                                               input logic [2:0] cas,
                                               input logic [1:0] opm,
                                               input logic       wrb);
        return {2'b00, wrb, opm, cas, btype, burst};
    endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
// Loadable down-counter that spaces commands.
// Loading value L makes done rise L cycles after the load edge.
// Assumes the caller loads only when it issues a command.
module sdr_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // Count down to zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done);

endmodule

// File: rtl/sdr_refresh_timer.sv
// Periodic refresh request generator.
// It runs only while run is high. Every INTERVAL cycles it sets a pending
// flag, and an acknowledge clears that flag. When both happen on the same
// edge, the expiry wins. Assumes INTERVAL >= 2.
module sdr_refresh_timer #(
    parameter int INTERVAL = 1292
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic pend
);

    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;
    logic          expire;

    assign expire = run && (cnt == '0);

    // Interval countdown, held at full value while not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      cnt <= CW'(INTERVAL - 1);
        else if (cnt == '0)      cnt <= CW'(INTERVAL - 1);
        else                     cnt <= cnt - 1'b1;
    end

    // Pending request flag
    always_ff @(posedge clk) begin
        if (!rst_n)              pend <= 1'b0;
        else if (expire)         pend <= 1'b1;
        else if (ack)            pend <= 1'b0;
    end

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire) |=> !pend);

    a_r7_idle_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pend);

endmodule

// File: rtl/sdr_init_fsm.sv
// Power-up and refresh sequencer. It drives CKE and the registered
// command and address, and it uses a wait timer to space the commands.
// Assumes all timing parameters are >= 1 and NUM_INIT_REF >= 1.
module sdr_init_fsm
    import sdr_seq_pkg::*;
#(
    parameter int PWRUP_CLKS   = 8400,
    parameter int TRP          = 2,
    parameter int TRC          = 6,
    parameter int TMRD         = 2,
    parameter int NUM_INIT_REF = 5,
    parameter int ADDR_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_hold,
    input  logic              ref_pend,
    output logic              ref_ack,
    output logic              cke,
    output sdr_cmd_t          cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              grant
);

    localparam int MAXT  = (PWRUP_CLKS > TRC) ? PWRUP_CLKS : TRC;
    localparam int TW    = $clog2(MAXT + 1);
    localparam int RW    = $clog2(NUM_INIT_REF + 1);
    localparam logic [11:0] MODE_WORD =
        build_mode(MW_BURST_2, MW_SEQ, MW_CAS_2, MW_OP_NORMAL, MW_WR_SINGLE);

    sdr_state_t    state;
    logic [RW-1:0] ref_left;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          issue_ref;

    sdr_wait_timer #(.W(TW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign issue_ref = (state == ST_USER) && ref_pend && !user_hold;
    assign ref_ack   = issue_ref;
    assign grant     = (state == ST_USER);

    // Pick the wait that follows the command issued this cycle
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_RESET: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(PWRUP_CLKS - 1);
            end
            ST_PWRUP: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(TRP - 1);
            end
            ST_PRE_WAIT: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(TRC - 1);
            end
            ST_AR_WAIT: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_val  = (ref_left != '0) ? TW'(TRC - 1) : TW'(TMRD - 1);
            end
            ST_USER: if (issue_ref) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(TRC - 1);
            end
            default: ;
        endcase
    end

    // Sequence state, command and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RESET;
            cke      <= 1'b0;
            cmd      <= CMD_NOP;
            addr     <= '0;
            ready    <= 1'b0;
            ref_left <= '0;
        end else begin
            cmd  <= CMD_NOP;
            addr <= '0;
            unique case (state)
                ST_RESET: begin
                    cke   <= 1'b1;
                    state <= ST_PWRUP;
                end
                ST_PWRUP: if (tmr_done) begin
                    cmd      <= CMD_PRE;
                    addr[10] <= 1'b1;
                    state    <= ST_PRE_WAIT;
                end
                ST_PRE_WAIT: if (tmr_done) begin
                    cmd      <= CMD_REF;
                    ref_left <= RW'(NUM_INIT_REF - 1);
                    state    <= ST_AR_WAIT;
                end
                ST_AR_WAIT: if (tmr_done) begin
                    if (ref_left != '0) begin
                        cmd      <= CMD_REF;
                        ref_left <= ref_left - 1'b1;
                    end else begin
                        cmd   <= CMD_LMR;
                        addr  <= ADDR_W'(MODE_WORD);
                        state <= ST_LMR_WAIT;
                    end
                end
                ST_LMR_WAIT: if (tmr_done) begin
                    ready <= 1'b1;
                    state <= ST_USER;
                end
                ST_USER: if (issue_ref) begin
                    cmd   <= CMD_REF;
                    state <= ST_REF_WAIT;
                end
                ST_REF_WAIT: if (tmr_done) state <= ST_USER;
                default: state <= ST_RESET;
            endcase
        end
    end

    a_r2_cke_stays: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    a_r6_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    a_r8_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ready);

    a_r10_hold_defers: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && user_hold) |=> (cmd == CMD_NOP));

endmodule

// File: rtl/sdram_pwrup_refresh.sv
// Top of the SDRAM power-up and refresh sequencer. It joins the sequencer
// and the refresh interval timer, and it passes the user command through
// to the pins while the bus is granted and held. Assumes the user port
// drives legal commands only while it holds the bus.
module sdram_pwrup_refresh
    import sdr_seq_pkg::*;
#(
    parameter int PWRUP_CLKS   = 8400,
    parameter int REF_INTERVAL = 1292,
    parameter int TRP          = 2,
    parameter int TRC          = 6,
    parameter int TMRD         = 2,
    parameter int NUM_INIT_REF = 5,
    parameter int ADDR_W       = 12,
    parameter int BA_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_hold,
    input  logic              user_cs_n,
    input  logic              user_ras_n,
    input  logic              user_cas_n,
    input  logic              user_we_n,
    input  logic [BA_W-1:0]   user_ba,
    input  logic [ADDR_W-1:0] user_addr,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_ready,
    output logic              sd_grant
);

    sdr_cmd_t          seq_cmd;
    logic [ADDR_W-1:0] seq_addr;
    logic              ref_pend;
    logic              ref_ack;
    logic              user_owns;

    sdr_init_fsm #(
        .PWRUP_CLKS   (PWRUP_CLKS),
        .TRP          (TRP),
        .TRC          (TRC),
        .TMRD         (TMRD),
        .NUM_INIT_REF (NUM_INIT_REF),
        .ADDR_W       (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .user_hold (user_hold),
        .ref_pend  (ref_pend),
        .ref_ack   (ref_ack),
        .cke       (sd_cke),
        .cmd       (seq_cmd),
        .addr      (seq_addr),
        .ready     (sd_ready),
        .grant     (sd_grant)
    );

    sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_reftmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sd_ready),
        .ack   (ref_ack),
        .pend  (ref_pend)
    );

    assign user_owns = sd_grant && user_hold;

    // Pin multiplexer: user command when it owns the bus, else sequencer
    always_comb begin
        if (user_owns) begin
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} =
                {user_cs_n, user_ras_n, user_cas_n, user_we_n};
            sd_ba   = user_ba;
            sd_addr = user_addr;
        end else begin
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = seq_cmd;
            sd_ba   = '0;
            sd_addr = seq_addr;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sd_cke && !sd_ready && !sd_grant));

endmodule

// File: tb/sdram_pwrup_refresh_test.sv
module sdram_pwrup_refresh_test;

    localparam int CLK_PERIOD = 10;
    localparam int PWRUP      = 8400;
    localparam int REFI       = 1292;
    localparam int T_RP       = 2;
    localparam int T_RC       = 6;
    localparam int T_MRD      = 2;
    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010,
                           ARF = 4'b0001, LMR = 4'b0000, ACT = 4'b0011;

    logic clk = 1'b0, rst_n = 1'b0;
    logic user_hold = 1'b0;
    logic [3:0] ucmd = 4'b0111;
    logic [1:0] user_ba = 2'b00;
    logic [11:0] user_addr = '0;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ready, sd_grant;
    logic [1:0] sd_ba;
    logic [11:0] sd_addr;

    int cyc = 0, n_chk = 0, n_bad = 0;
    int ready_cyc = 0, last_ar = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_pwrup_refresh #(.PWRUP_CLKS(PWRUP), .REF_INTERVAL(REFI)) uut (
        .clk(clk), .rst_n(rst_n), .user_hold(user_hold),
        .user_cs_n(ucmd[3]), .user_ras_n(ucmd[2]),
        .user_cas_n(ucmd[1]), .user_we_n(ucmd[0]),
        .user_ba(user_ba), .user_addr(user_addr),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_ready(sd_ready), .sd_grant(sd_grant));

    function automatic logic [3:0] pins();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Wait for the next non-NOP command on the pins
    task automatic next_cmd(output int c, output logic [3:0] k,
                            output logic [11:0] a, output logic [1:0] b);
        do @(negedge clk); while (pins() == NOP);
        c = cyc; k = pins(); a = sd_addr; b = sd_ba;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "cke in reset", sd_cke, 0);
        check("R1", "cmd in reset", pins(), NOP);
        check("R1", "ready in reset", sd_ready, 0);
        check("R1", "grant in reset", sd_grant, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_init();
        int c0, c, prev; logic [3:0] k; logic [11:0] a; logic [1:0] b;
        @(negedge clk);
        c0 = cyc;
        check("R2", "cke after reset release", sd_cke, 1);
        next_cmd(c, k, a, b);
        check("R3", "first command is precharge", k, PRE);
        check("R3", "A10 on precharge", a[10], 1);
        check("R3", "power-up gap", c - c0, PWRUP);
        prev = c;
        for (int i = 0; i < 5; i++) begin
            next_cmd(c, k, a, b);
            check("R4", "init refresh code", k, ARF);
            check("R4", "init refresh gap", c - prev, (i == 0) ? T_RP : T_RC);
            prev = c;
        end
        next_cmd(c, k, a, b);
        check("R5", "load mode code", k, LMR);
        check("R5", "mode word", a, 12'h221);
        check("R5", "mode bank", b, 0);
        check("R5", "load mode gap", c - prev, T_RC);
        check("R6", "ready low at load mode", sd_ready, 0);
        check("R2", "cke still high", sd_cke, 1);
        while (!sd_ready) @(negedge clk);
        ready_cyc = cyc;
        check("R6", "ready delay", ready_cyc - c, T_MRD);
    endtask

    task automatic t_idle_refresh();
        int c; logic [3:0] k; logic [11:0] a; logic [1:0] b;
        next_cmd(c, k, a, b);
        check("R7", "first periodic refresh code", k, ARF);
        check("R7", "first periodic refresh delay", c - ready_cyc, REFI + 1);
        check("R8", "grant dropped at refresh", sd_grant, 0);
        repeat (T_RC - 1) @(negedge clk);
        check("R8", "grant low before tRC", sd_grant, 0);
        @(negedge clk);
        check("R8", "grant back after tRC", sd_grant, 1);
        check("R9", "NOP while granted and idle", pins(), NOP);
        last_ar = c;
        next_cmd(c, k, a, b);
        check("R7", "refresh spacing", c - last_ar, REFI);
        last_ar = c;
        check("R6", "ready stays high", sd_ready, 1);
    endtask

    task automatic t_hold_defer();
        int c, bad_cyc, rel; logic [3:0] k; logic [11:0] a; logic [1:0] b;
        repeat (T_RC + 2) @(negedge clk);
        ucmd = ACT; user_ba = 2'b10; user_addr = 12'h5A3; user_hold = 1'b1;
        @(negedge clk);
        check("R9", "user command passes", pins(), ACT);
        check("R9", "user bank passes", sd_ba, 2'b10);
        check("R9", "user address passes", sd_addr, 12'h5A3);
        bad_cyc = 0;
        for (int i = 0; i < REFI + 50; i++) begin
            @(negedge clk);
            if (pins() != ACT || !sd_grant) bad_cyc++;
        end
        check("R10", "cycles with refresh or lost grant during hold", bad_cyc, 0);
        user_hold = 1'b0;
        #1;
        rel = cyc;
        check("R9", "user inputs ignored without hold", pins(), NOP);
        check("R9", "bank ignored without hold", sd_ba, 0);
        next_cmd(c, k, a, b);
        check("R10", "deferred refresh code", k, ARF);
        check("R10", "deferred refresh timing", c - rel, 1);
        ucmd = NOP;
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "cke drops on reset", sd_cke, 0);
        check("R1", "ready drops on reset", sd_ready, 0);
        check("R1", "grant drops on reset", sd_grant, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "cke rises again", sd_cke, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_init();
        t_idle_refresh();
        t_hold_defer();
        t_reset_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule